// File: doc/BRIEF.md
# Multimode 16-bit Up/Down Timer

This block is a single 16-bit timer/counter under CPU control. It runs in one of three modes. In timer mode it advances on ticks from an internal prescaler. In gated mode it takes those same ticks only while a gate pin sits at a chosen level. In counter mode it advances on chosen edges of that same pin. Each step moves the count up or down by one. The direction comes from a control bit, or from an external direction pin whose sense can be inverted.

When the count passes its end in either direction it wraps. On each wrap a one-cycle pulse is raised, a toggle output changes level, and a sticky request flag is set. Software clears the flag by writing a one to it.

The CPU reaches two words through a small register port. Address 0 is the count and address 1 is the control word. A write takes effect on the clock edge where the write strobe is high. A read is combinational from the address. There is no stream data path, so the port has no valid/ready handshake: a write strobe is always accepted in the cycle it is presented.

Top module: `gpt16_timer`

## Requirements
- R1: After reset the count and control word read as 0, and tog_out, ovf_pulse and irq are low.
- R2: In timer mode (control bits [4:3] = 0) with run set (bit 5), the count steps once every 8·2^n clock cycles, where n is control bits [2:0]. The first step lands on the 8·2^n-th rising edge after the edge that set run.
- R3: In gated mode (bits [4:3] = 1) prescaler ticks are counted only while the synchronised gate pin equals control bit 9: 1 means active high, 0 means active low.
- R4: In counter mode (bits [4:3] = 2), bits [11:10] pick the counted edge of the pin: 01 rising, 10 falling, 11 both, 00 none. The pin passes two synchroniser stages, so a change made before edge k shows in the count after edge k+2.
- R5: The direction is down when bit 6 is set, provided bit 7 is clear. When bit 7 is set, the synchronised direction pin decides instead: high means down, and bit 8 reverses this.
- R6: Counting up from 0xFFFF gives 0x0000, and counting down from 0x0000 gives 0xFFFF. On that edge ovf_pulse goes high for one cycle and tog_out changes level.
- R7: Every wrap sets the flag at control bit 12, and irq shows it. Writing the control word with bit 12 = 1 clears the flag. Writing with bit 12 = 0 leaves it set.
- R8: A CPU write of the count on the edge where a step would occur stores the written value. The step is lost, and it produces no ovf_pulse and no toggle.
- R9: With run clear the count holds its value, and the prescaler restarts from zero.
- R10: Control bits [11:0] read back as written. Mode value 3 never counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = count, 1 = control |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| tmr_pin | input | 1 | Gate level (gated mode) or count source (counter mode) |
| dir_pin | input | 1 | External direction, high = down |
| tog_out | output | 1 | Changes level on every wrap |
| ovf_pulse | output | 1 | One-cycle wrap pulse |
| irq | output | 1 | Sticky wrap request flag |

## Verification
Timer mode is run at the smallest, a middle and the largest prescale setting, counting up and down, so that a wrong tick period or a first-tick offset gives a different count. Preloads next to 0xFFFF and 0x0000 separate correct wrapping from saturation, and the bench samples the pulse and the toggle on the exact edge of each wrap. The pin is driven with level patterns to check both gate polarities. It is then driven with pulse trains under each edge selection, which separates rising, falling, both and none, and one cycle-by-cycle probe fixes the synchroniser latency. A CPU write placed on a step edge, and on a wrap edge, shows that the write wins and that the lost step raises no wrap indication.

// File: rtl/gpt16_pkg.sv
package gpt16_pkg;
  localparam int REG_W  = 16;
  localparam int PSC_W  = 3;
  localparam int CTRL_W = 12;
  localparam int FLAG_BIT = CTRL_W;

  typedef enum logic [1:0] {
    MD_TIMER = 2'd0,
    MD_GATED = 2'd1,
    MD_COUNT = 2'd2,
    MD_HOLD  = 2'd3
  } run_mode_e;

  // Field order is the register layout, MSB first: bits [11:0].
  typedef struct packed {
    logic [1:0]       edge_sel;  // 01 rise, 10 fall, 11 both
    logic             gate_hi;
    logic             dir_inv;
    logic             dir_ext;
    logic             dir_down;
    logic             run;
    run_mode_e        mode;
    logic [PSC_W-1:0] psc;
  } ctrl_t;
endpackage

// File: rtl/gpt16_sync.sv
module gpt16_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1   <= '0;
      sync_out <= '0;
    end else begin
      stage1   <= async_in;
      sync_out <= stage1;
    end
  end
endmodule

// File: rtl/gpt16_prescaler.sv
module gpt16_prescaler #(
  parameter int PSC_W      = 3,
  parameter int BASE_SHIFT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);
  localparam int MAX_N = (1 << PSC_W) - 1;
  localparam int CW    = BASE_SHIFT + MAX_N;

  logic [CW-1:0] div_q;
  logic [CW-1:0] mask;

  // Mask keeps BASE_SHIFT + psc low ones: tick period 2^(BASE_SHIFT+psc).
  assign mask = {CW{1'b1}} >> (MAX_N - int'(psc));
  assign tick = run && ((div_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    div_q <= '0;
    else if (!run) div_q <= '0;
    else           div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/gpt16_edge.sv
module gpt16_edge (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sig_s,
  input  logic [1:0] edge_sel,
  output logic       evt
);
  logic sig_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_d <= 1'b0;
    else        sig_d <= sig_s;
  end

  assign evt = (edge_sel[0] && sig_s && !sig_d) ||
               (edge_sel[1] && !sig_s && sig_d);
endmodule

// File: rtl/gpt16_timer.sv
module gpt16_timer
  import gpt16_pkg::*;
#(
  parameter int WIDTH      = 16,
  parameter int BASE_SHIFT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             tmr_pin,
  input  logic             dir_pin,
  output logic             tog_out,
  output logic             ovf_pulse,
  output logic             irq
);
  ctrl_t            ctrl_q;
  logic [WIDTH-1:0] count_q;
  logic             flag_q;
  logic             run_en;
  logic             pin_s, dir_s;
  logic             tick, evt;
  logic             wr_cnt, wr_ctl;
  logic             step, down, at_end, wrap;
  logic             unused_hi;

  assign run_en    = ctrl_q.run;
  assign wr_cnt    = reg_we && !reg_addr;
  assign wr_ctl    = reg_we && reg_addr;
  assign unused_hi = &reg_wdata[REG_W-1:FLAG_BIT+1];

  gpt16_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({dir_pin, tmr_pin}),
    .sync_out({dir_s, pin_s})
  );

  gpt16_prescaler #(.PSC_W(PSC_W), .BASE_SHIFT(BASE_SHIFT)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(run_en), .psc(ctrl_q.psc), .tick(tick)
  );

  gpt16_edge u_edge (
    .clk(clk), .rst_n(rst_n), .sig_s(pin_s),
    .edge_sel(ctrl_q.edge_sel), .evt(evt)
  );

  always_comb begin
    unique case (ctrl_q.mode)
      MD_TIMER: step = run_en && tick;
      MD_GATED: step = run_en && tick && (pin_s == ctrl_q.gate_hi);
      MD_COUNT: step = run_en && evt;
      default:  step = 1'b0;
    endcase
  end

  assign down   = ctrl_q.dir_ext ? (dir_s ^ ctrl_q.dir_inv) : ctrl_q.dir_down;
  assign at_end = down ? (count_q == '0) : (count_q == '1);
  assign wrap   = step && at_end && !wr_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q   <= '0;
      ctrl_q    <= '0;
      flag_q    <= 1'b0;
      ovf_pulse <= 1'b0;
      tog_out   <= 1'b0;
    end else begin
      if (wr_cnt)    count_q <= reg_wdata[WIDTH-1:0];
      else if (step) count_q <= down ? count_q - 1'b1 : count_q + 1'b1;
      if (wr_ctl) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
      if (wrap)                                flag_q <= 1'b1;
      else if (wr_ctl && reg_wdata[FLAG_BIT])  flag_q <= 1'b0;
      ovf_pulse <= wrap;
      tog_out   <= tog_out ^ wrap;
    end
  end

  assign irq       = flag_q;
  assign reg_rdata = reg_addr ? REG_W'({flag_q, ctrl_q}) : REG_W'(count_q);
endmodule

// File: rtl/gpt16_timer_chk.sv
module gpt16_timer_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic             reg_addr,
  input logic [15:0]      reg_wdata,
  input logic [WIDTH-1:0] count_q,
  input logic             run_en,
  input logic             tog_out,
  input logic             ovf_pulse,
  input logic             irq
);
  // R8
  cpu_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !reg_addr) |=> count_q == $past(reg_wdata[WIDTH-1:0]));

  // R6
  tog_follows_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse == (tog_out != $past(tog_out)));

  // R6
  wrap_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> (count_q == '0 || count_q == '1));

  // R7
  irq_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> irq);

  // R9
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !(reg_we && !reg_addr)) |=> $stable(count_q));

  // R2
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && !reg_addr) |=> (count_q == $past(count_q) ||
      count_q == WIDTH'($past(count_q) + 1'b1) ||
      count_q == WIDTH'($past(count_q) - 1'b1)));
endmodule

bind gpt16_timer gpt16_timer_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .count_q(count_q), .run_en(run_en),
  .tog_out(tog_out), .ovf_pulse(ovf_pulse), .irq(irq)
);

// File: tb/tb_gpt16_timer.sv
module tb_gpt16_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic        reg_addr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        tmr_pin = 1'b0;
  logic        dir_pin = 1'b0;
  logic        tog_out, ovf_pulse, irq;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  gpt16_timer dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmr_pin(tmr_pin),
    .dir_pin(dir_pin), .tog_out(tog_out), .ovf_pulse(ovf_pulse), .irq(irq)
  );

  // {ctrl, preload, edges to wait, expected count}
  localparam logic [63:0] VEC [10] = '{
    {16'h0020, 16'h0100, 16'd40,   16'h0105},  // R2 n=0 up
    {16'h0021, 16'h0000, 16'd33,   16'h0002},  // R2 n=1
    {16'h0062, 16'h0010, 16'd100,  16'h000D},  // R5 soft down, n=2
    {16'h0020, 16'hFFFE, 16'd24,   16'h0001},  // R6 up through wrap
    {16'h0060, 16'h0001, 16'd16,   16'hFFFF},  // R6 down through wrap
    {16'h0027, 16'h0000, 16'd1024, 16'h0001},  // R2 n=7
    {16'h0038, 16'h0055, 16'd40,   16'h0055},  // R10 mode 3 holds
    {16'h0000, 16'h0077, 16'd40,   16'h0077},  // R9 run clear
    {16'h00A0, 16'h0005, 16'd16,   16'h0007},  // R5 pin low = up
    {16'h01A0, 16'h0005, 16'd16,   16'h0003}   // R5 pin inverted = down
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called just after a falling edge; returns just after the next one.
  task automatic wr(input logic a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [15:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic load(input logic [15:0] ctl, input logic [15:0] pre);
    wr(1'b1, 16'h0000); wr(1'b0, pre); wr(1'b1, ctl);
  endtask

  task automatic pulses(input int n);
    for (int k = 0; k < n; k++) begin
      tmr_pin = 1'b1; repeat (4) @(negedge clk);
      tmr_pin = 1'b0; repeat (4) @(negedge clk);
    end
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    logic t0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(1'b0, v); chk("R1 count", v, 16'h0000);
    rd(1'b1, v); chk("R1 ctrl", v, 16'h0000);
    chk("R1 outputs", {13'd0, tog_out, ovf_pulse, irq}, 16'h0000);

    // R10 readback of every control field
    @(negedge clk);
    wr(1'b1, 16'h0FFF);
    rd(1'b1, v); chk("R10 ctrl readback", v, 16'h0FFF);
    @(negedge clk);

    // Table walk
    for (int i = 0; i < 10; i++) begin
      load(VEC[i][63:48], VEC[i][47:32]);
      repeat (int'(VEC[i][31:16])) @(negedge clk);
      rd(1'b0, v);
      chk($sformatf("R2/R5/R6/R9/R10 vector %0d", i), v, VEC[i][15:0]);
      @(negedge clk);
    end

    // R6 exact wrap edge
    load(16'h0000, 16'hFFFF);
    wr(1'b1, 16'h0020);
    t0 = tog_out;
    repeat (7) @(negedge clk);
    rd(1'b0, v); chk("R6 before wrap", {v[14:0], ovf_pulse}, {15'h7FFF, 1'b0});
    @(negedge clk);
    rd(1'b0, v); chk("R6 wrap count", v, 16'h0000);
    chk("R6 wrap pulse+toggle", {14'd0, ovf_pulse, tog_out}, {14'd0, 1'b1, ~t0});
    @(negedge clk);
    chk("R6 pulse one cycle", {15'd0, ovf_pulse}, 16'h0000);

    // R7 sticky flag
    @(negedge clk);
    wr(1'b1, 16'h0000);
    chk("R7 write 0 keeps flag", {15'd0, irq}, 16'h0001);
    wr(1'b1, 16'h1000);
    chk("R7 write 1 clears flag", {15'd0, irq}, 16'h0000);

    // R8 write on a wrap edge
    load(16'h0000, 16'hFFFF);
    wr(1'b1, 16'h0020);
    t0 = tog_out;
    repeat (7) @(negedge clk);
    wr(1'b0, 16'h0005);
    rd(1'b0, v); chk("R8 write wins", v, 16'h0005);
    chk("R8 no wrap signs", {14'd0, ovf_pulse, tog_out, irq}, {14'd0, 1'b0, t0, 1'b0});
    repeat (8) @(negedge clk);
    rd(1'b0, v); chk("R8 counting resumes", v, 16'h0006);
    @(negedge clk);

    // R3 gated, both polarities (pin held low)
    load(16'h0028, 16'h0000);
    repeat (40) @(negedge clk);
    rd(1'b0, v); chk("R3 active-low gate open", v, 16'h0005);
    @(negedge clk);
    load(16'h0228, 16'h0000);
    repeat (40) @(negedge clk);
    rd(1'b0, v); chk("R3 active-high gate shut", v, 16'h0000);
    @(negedge clk);
    tmr_pin = 1'b1; repeat (4) @(negedge clk);
    load(16'h0228, 16'h0000);
    repeat (40) @(negedge clk);
    rd(1'b0, v); chk("R3 active-high gate open", v, 16'h0005);
    @(negedge clk);
    tmr_pin = 1'b0; repeat (4) @(negedge clk);

    // R4 synchroniser latency
    load(16'h0430, 16'h0000);
    tmr_pin = 1'b1;
    repeat (2) @(negedge clk);
    rd(1'b0, v); chk("R4 not yet counted", v, 16'h0000);
    @(negedge clk);
    rd(1'b0, v); chk("R4 counted after third edge", v, 16'h0001);
    @(negedge clk);
    tmr_pin = 1'b0; repeat (4) @(negedge clk);

    // R4 edge selections
    load(16'h0430, 16'h0000); pulses(3);
    rd(1'b0, v); chk("R4 rising", v, 16'h0003); @(negedge clk);
    load(16'h0830, 16'h0000); pulses(3);
    rd(1'b0, v); chk("R4 falling", v, 16'h0003); @(negedge clk);
    load(16'h0C30, 16'h0000); pulses(3);
    rd(1'b0, v); chk("R4 both", v, 16'h0006); @(negedge clk);
    load(16'h0030, 16'h0000); pulses(3);
    rd(1'b0, v); chk("R4 none", v, 16'h0000); @(negedge clk);

    // R5 direction pin high
    dir_pin = 1'b1; repeat (4) @(negedge clk);
    load(16'h04B0, 16'h000A); pulses(2);
    rd(1'b0, v); chk("R5 pin high down", v, 16'h0008); @(negedge clk);
    load(16'h05B0, 16'h000A); pulses(2);
    rd(1'b0, v); chk("R5 pin high inverted up", v, 16'h000C);

    finish_run();
  end
endmodule